// File: doc/BRIEF.md
# Buffer Interrupt Vector Encoder

This block watches the interrupt state of a bank of message buffers and names, for each direction, the pending buffer that the interrupt service routine should handle first. A buffer counts as pending only when its interrupt status flag and its interrupt enable are both set. A per-buffer direction bit marks the buffer as transmit or receive, which decides the search it joins. Among the pending buffers of one direction, the smallest buffer number wins.

The two results are packed into one 16-bit read-only vector word. The transmit index sits in bits 14 to 8 and the receive index sits in bits 6 to 0. The result is registered on every clock, so the word follows its inputs one cycle later. A field with nothing pending reads zero. The number of populated buffers is a parameter of at most 128. Index positions at or above that count never take part.

Top module: `bivec_encoder`

## Requirements
- R1: A buffer is considered only if both its status flag bit and its enable bit are 1; with either bit at 0 it is never reported.
- R2: Among qualifying buffers of one direction, the field holds the smallest buffer index.
- R3: The transmit index is placed in vec_o[14:8] and the receive index in vec_o[6:0].
- R4: vec_o[15] and vec_o[7] always read 0.
- R5: A field reads 0 when no buffer of its direction qualifies.
- R6: While rst_ni is low, vec_o is all zeros.
- R7: dir_i[b]=1 places buffer b in the transmit search and dir_i[b]=0 places it in the receive search; a buffer never affects the field of the other direction.
- R8: vec_o reflects the flag, enable and direction inputs sampled at the previous rising clock edge: exactly one cycle of latency.
- R9: Buffer indices at or above NUM_BUF never qualify, whatever their input bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | 128 | Per-buffer interrupt status flags, bit b for buffer b |
| enable_i | input | 128 | Per-buffer interrupt enables |
| dir_i | input | 128 | Per-buffer direction, 1 = transmit, 0 = receive |
| vec_o | output | 16 | Packed vector word: transmit index, receive index, reserved zeros |

## Verification
The transmit search and the receive search resolve in the same cycle from the same input words, so an error in one can corrupt the other. The bench provokes this with patterns in which both directions have pending buffers at the same time, sometimes interleaved at neighbouring indices and sometimes sharing an index that differs only in its direction bit. Each cycle's whole word is compared with a reference loop, so a buffer that leaks into the wrong field, or a field that is overwritten by the other, shows up as a mismatch in a named field.

// File: rtl/bivec_pkg.sv
package bivec_pkg;

    // Width of one buffer index field and the register word
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned REG_W  = 16;
    // Number of index positions addressable by one field
    localparam int unsigned SLOTS  = 1 << IDX_W;

    // Direction encoding of the per-buffer tag
    localparam logic DIR_RX = 1'b0;
    localparam logic DIR_TX = 1'b1;

    // Registered state of the encoder
    typedef struct packed {
        logic [IDX_W-1:0] tx_idx;
        logic [IDX_W-1:0] rx_idx;
    } vec_state_t;

    // Pack the state into the visible word; reserved bits stay zero
    function automatic logic [REG_W-1:0] pack_word(input vec_state_t st);
        return {1'b0, st.tx_idx, 1'b0, st.rx_idx};
    endfunction

endpackage

// File: rtl/bivec_qualify.sv
module bivec_qualify
    import bivec_pkg::*;
#(
    parameter int unsigned NUM_BUF = SLOTS
) (
    input  logic [SLOTS-1:0] flag_i,
    input  logic [SLOTS-1:0] enable_i,
    input  logic [SLOTS-1:0] dir_i,
    output logic [SLOTS-1:0] qual_tx_o,
    output logic [SLOTS-1:0] qual_rx_o
);

    // One gating cell per index position; unpopulated positions tie off
    for (genvar b = 0; b < SLOTS; b++) begin : g_slot
        if (b < NUM_BUF) begin : g_live
            logic pend;
            assign pend         = flag_i[b] & enable_i[b];
            assign qual_tx_o[b] = pend & (dir_i[b] == DIR_TX);
            assign qual_rx_o[b] = pend & (dir_i[b] == DIR_RX);
        end else begin : g_dead
            assign qual_tx_o[b] = 1'b0;
            assign qual_rx_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/bivec_lowest_find.sv
module bivec_lowest_find #(
    parameter int unsigned WIDTH = 128,
    localparam int unsigned OUT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [OUT_W-1:0] idx_o,
    output logic             hit_o
);

    // Scan from the top down so the last match kept is the lowest index
    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = OUT_W'(i);
                hit_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bivec_encoder.sv
module bivec_encoder
    import bivec_pkg::*;
#(
    parameter int unsigned NUM_BUF = SLOTS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SLOTS-1:0] flag_i,
    input  logic [SLOTS-1:0] enable_i,
    input  logic [SLOTS-1:0] dir_i,
    output logic [REG_W-1:0] vec_o
);

    localparam int unsigned N_DIR = 2;
    localparam int unsigned SEL_RX = 0;
    localparam int unsigned SEL_TX = 1;

    logic [SLOTS-1:0] qual_tx;
    logic [SLOTS-1:0] qual_rx;
    logic [SLOTS-1:0] qual_set [N_DIR];
    logic [IDX_W-1:0] low_idx  [N_DIR];
    logic             low_hit  [N_DIR];

    vec_state_t st_d, st_q;

    bivec_qualify #(
        .NUM_BUF (NUM_BUF)
    ) u_qualify (
        .flag_i    (flag_i),
        .enable_i  (enable_i),
        .dir_i     (dir_i),
        .qual_tx_o (qual_tx),
        .qual_rx_o (qual_rx)
    );

    assign qual_set[SEL_RX] = qual_rx;
    assign qual_set[SEL_TX] = qual_tx;

    // One independent search per direction
    for (genvar d = 0; d < N_DIR; d++) begin : g_search
        bivec_lowest_find #(
            .WIDTH (SLOTS)
        ) u_find (
            .req_i (qual_set[d]),
            .idx_o (low_idx[d]),
            .hit_o (low_hit[d])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.tx_idx = low_hit[SEL_TX] ? low_idx[SEL_TX] : '0;
        st_d.rx_idx = low_hit[SEL_RX] ? low_idx[SEL_RX] : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o = pack_word(st_q);

endmodule

// File: rtl/bivec_encoder_chk.sv
module bivec_encoder_chk
    import bivec_pkg::*;
#(
    parameter int unsigned NUM_BUF = SLOTS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SLOTS-1:0] flag_i,
    input  logic [SLOTS-1:0] enable_i,
    input  logic [SLOTS-1:0] dir_i,
    input  logic [REG_W-1:0] vec_o
);

    logic [SLOTS-1:0] live;
    logic [SLOTS-1:0] tx_seen_q, rx_seen_q;
    logic [IDX_W-1:0] tx_f, rx_f;

    always_comb begin
        live = '0;
        for (int b = 0; b < SLOTS; b++) begin
            live[b] = (b < NUM_BUF);
        end
    end

    // Qualifying sets as they were at the last edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_seen_q <= '0;
            rx_seen_q <= '0;
        end else begin
            tx_seen_q <= flag_i & enable_i & dir_i & live;
            rx_seen_q <= flag_i & enable_i & ~dir_i & live;
        end
    end

    assign tx_f = vec_o[14:8];
    assign rx_f = vec_o[6:0];

    // R6: reset clears the word
    a_r6_reset_zero: assert property (@(posedge clk_i)
        !rst_ni |-> vec_o == '0);

    // R4: reserved bits read zero
    a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_o[15] == 1'b0 && vec_o[7] == 1'b0);

    // R5: empty direction yields zero field
    a_r5_tx_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_seen_q == '0 |-> tx_f == '0);
    a_r5_rx_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_seen_q == '0 |-> rx_f == '0);

    // R2, R7, R9: reported index qualifies in its own direction, nothing lower does
    a_r2_tx_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_seen_q != '0 |-> tx_seen_q[tx_f] &&
            ((tx_seen_q & ~({SLOTS{1'b1}} << tx_f)) == '0));
    a_r2_rx_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_seen_q != '0 |-> rx_seen_q[rx_f] &&
            ((rx_seen_q & ~({SLOTS{1'b1}} << rx_f)) == '0));

endmodule

bind bivec_encoder bivec_encoder_chk #(
    .NUM_BUF (NUM_BUF)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_i   (flag_i),
    .enable_i (enable_i),
    .dir_i    (dir_i),
    .vec_o    (vec_o)
);

// File: tb/bivec_encoder_tb.sv
module bivec_encoder_tb;

    localparam int SLOTS   = 128;
    localparam int SMALL_N = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SLOTS-1:0]  flag = '0;
    logic [SLOTS-1:0]  en = '0;
    logic [SLOTS-1:0]  dir = '0;
    logic [15:0]       vec;
    logic [15:0]       vec_small;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    bivec_encoder u_dut (
        .clk_i (clk), .rst_ni (rst_n), .flag_i (flag),
        .enable_i (en), .dir_i (dir), .vec_o (vec)
    );

    bivec_encoder #(.NUM_BUF(SMALL_N)) u_dut_small (
        .clk_i (clk), .rst_ni (rst_n), .flag_i (flag),
        .enable_i (en), .dir_i (dir), .vec_o (vec_small)
    );

    // Reference model from the requirements
    function automatic logic [15:0] ref_word(input logic [SLOTS-1:0] f,
        input logic [SLOTS-1:0] e, input logic [SLOTS-1:0] d, input int nbuf);
        logic [6:0] t, r;
        logic ft, fr;
        t = '0; r = '0; ft = 1'b0; fr = 1'b0;
        for (int b = 0; b < nbuf; b++) begin
            if (f[b] && e[b]) begin
                if (d[b] && !ft) begin t = 7'(b); ft = 1'b1; end
                if (!d[b] && !fr) begin r = 7'(b); fr = 1'b1; end
            end
        end
        return {1'b0, t, 1'b0, r};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got tx=%0d rx=%0d (0x%04h), expected tx=%0d rx=%0d (0x%04h)",
                     req, got[14:8], got[6:0], got, exp[14:8], exp[6:0], exp);
        end
    endtask

    // Drive at the falling edge, then sample just after the next rising edge
    task automatic apply(input logic [SLOTS-1:0] f, input logic [SLOTS-1:0] e,
                         input logic [SLOTS-1:0] d);
        @(negedge clk);
        flag = f; en = e; dir = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        flag = '1; en = '1; dir = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R6 reset", vec, 16'h0000);
        @(negedge clk);
        flag = '0; en = '0; dir = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R5 idle after reset", vec, 16'h0000);
    endtask

    task automatic t_fields();
        logic [SLOTS-1:0] one_hi;
        one_hi = '0; one_hi[37] = 1'b1;
        apply(one_hi, one_hi, one_hi);
        check("R3 tx field position", vec, {1'b0, 7'd37, 8'h00});
        apply(one_hi, one_hi, '0);
        check("R3 rx field position", vec, {8'h00, 1'b0, 7'd37});
        apply('1, '1, {SLOTS{1'b0}} | (SLOTS'(1) << 127));
        check("R4 reserved bits, tx=127", vec, {1'b0, 7'd127, 1'b0, 7'd0});
    endtask

    task automatic t_gating();
        logic [SLOTS-1:0] f, e;
        f = '0; e = '0;
        f[5] = 1'b1; e[9] = 1'b1; f[20] = 1'b1; e[20] = 1'b1;
        apply(f, e, '0);
        check("R1 flag or enable alone ignored", vec, {8'h00, 1'b0, 7'd20});
        apply('1, '0, '1);
        check("R1 all flags without enables", vec, 16'h0000);
        apply('0, '1, '0);
        check("R1 all enables without flags", vec, 16'h0000);
    endtask

    task automatic t_priority();
        logic [SLOTS-1:0] f, d;
        f = '0; d = '0;
        f[3] = 1'b1; f[64] = 1'b1; f[100] = 1'b1;
        f[4] = 1'b1; f[90] = 1'b1; d[4] = 1'b1; d[90] = 1'b1;
        apply(f, '1, d);
        check("R2 lowest of several", vec, {1'b0, 7'd4, 1'b0, 7'd3});
        apply('1, '1, '0);
        check("R2 all rx pending picks 0", vec, 16'h0000);
        apply('1, '1, 128'h1 << 126 | 128'h1 << 127);
        check("R2 top tx indices", vec, {1'b0, 7'd126, 1'b0, 7'd0});
    endtask

    task automatic t_direction();
        logic [SLOTS-1:0] f, d;
        f = '0; f[10] = 1'b1; f[11] = 1'b1;
        d = '0; d[10] = 1'b1;
        apply(f, '1, d);
        check("R7 neighbours split by direction", vec, {1'b0, 7'd10, 1'b0, 7'd11});
        apply(f, '1, ~d);
        check("R7 direction swap", vec, {1'b0, 7'd11, 1'b0, 7'd10});
        apply('0, '1, '1);
        check("R5 nothing pending", vec, 16'h0000);
    endtask

    task automatic t_latency();
        logic [SLOTS-1:0] f;
        f = '0; f[55] = 1'b1;
        @(negedge clk);
        flag = f; en = '1; dir = '1;
        #1;
        check("R8 unchanged before edge", vec, 16'h0000);
        @(posedge clk); #1;
        check("R8 updated after one edge", vec, {1'b0, 7'd55, 8'h00});
    endtask

    task automatic t_small();
        logic [SLOTS-1:0] f;
        f = '0; f[SMALL_N] = 1'b1; f[SMALL_N + 20] = 1'b1;
        apply(f, '1, '0);
        check("R9 out-of-range ignored", vec_small, 16'h0000);
        check("R9 full instance sees it", vec, ref_word(f, '1, '0, SLOTS));
        f[SMALL_N - 1] = 1'b1;
        apply(f, '1, '1);
        check("R9 last in-range index", vec_small, {1'b0, 7'(SMALL_N - 1), 8'h00});
    endtask

    task automatic t_random();
        logic [SLOTS-1:0] f, e, d;
        for (int n = 0; n < 300; n++) begin
            for (int w = 0; w < 4; w++) begin
                f[w*32 +: 32] = $urandom & $urandom & $urandom;
                e[w*32 +: 32] = $urandom | $urandom;
                d[w*32 +: 32] = $urandom;
            end
            if (n % 3 == 0) begin
                f[63:0] = '0;
            end
            apply(f, e, d);
            check("R2/R7 random vs reference", vec, ref_word(f, e, d, SLOTS));
            check("R9 random small vs reference", vec_small, ref_word(f, e, d, SMALL_N));
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fields();
        t_gating();
        t_priority();
        t_direction();
        t_latency();
        t_small();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule